// File: doc/BRIEF.md
# Low-Frequency Carrier Generator and Sample Serializer

This block sits between a low-frequency reader front end and a host processor. From one main clock (24 MHz in the target system) it makes a square-wave carrier for the antenna coil drivers and an A/D converter clock with the same period. Each 8-bit sample that the converter presents is captured and sent to the host as a framed word on a synchronous serial port made of a clock, a frame line and a data line.

Three timing sources can be chosen. Two fixed rates are picked by a select pin: 125 kHz, or about 136 kHz. A third rate is set by an 8-bit divisor. In every case the serial bit clock comes from the same divider as the carrier. As a result, each carrier period holds exactly eight serial bit periods and so carries exactly one sample word.

The carrier period is split into sixteen equal slots by an accumulating phase stepper. An odd slot raises the serial clock. Entering slot 0 starts a new carrier period. Entering the middle slot raises the A/D clock and captures the sample.

The serial port is free-running. It has no valid/ready handshake, so the host cannot apply back-pressure. A word is lost if the host does not take it within its carrier period. The unused high-frequency power output is held low.

Top module: `lfc_reader_front`

## Requirements
- R1: With `div_mode`=0, the carrier period is 16×(11+`sel_125k`) main clocks: 192 clocks when `sel_125k`=1 and 176 clocks when `sel_125k`=0. `div_value` has no effect in this mode.
- R2: `ser_clk` has eight rising edges in every carrier period. Its period is one eighth of the carrier period.
- R3: With `div_mode`=1, the carrier period is 2×(D+1) main clocks, where D is the effective divisor. For example, D=95 gives 192 clocks. `coil_drive` is high for the first half of the period, which is exactly (D+1) clocks.
- R4: A `div_value` below 19 is treated as 19, giving a 40-clock period. Values from 19 to 255 are used as given.
- R5: A word is sent most significant bit first, one bit per `ser_clk` period. `ser_data` changes only on a falling edge of `ser_clk`, so a receiver samples it on the rising edge.
- R6: `ser_frame` rises together with the first bit of a word, at the start of a carrier period (the rising edge of `coil_drive`). It stays high while bits are shifted. It stays low during the first carrier period after reset, because no sample has been captured yet.
- R7: `adc_sample` is captured on the rising edge of `adc_clk`, halfway through a carrier period. That value is the word sent in the next carrier period. Changes to `adc_sample` at other times do not affect that word.
- R8: `adc_clk` has the carrier period and is the inverse of `coil_drive`, high during the second half of the period. `dbg_clk` always equals `adc_clk`.
- R9: `hf_power` is always 0.
- R10: While `rst` is high, `coil_drive`, `adc_clk`, `ser_clk`, `ser_frame` and `ser_data` are 0. On the first clock edge where `rst` is sampled low, a carrier period begins with `coil_drive` going to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_125k | input | 1 | Fixed-rate select: 1 = 125 kHz, 0 = about 136 kHz |
| div_mode | input | 1 | 1 = use `div_value` for the carrier period |
| div_value | input | 8 | Programmable divisor (clamped up to 19) |
| adc_sample | input | 8 | Converter sample, captured on the rising edge of `adc_clk` |
| coil_drive | output | 1 | Carrier to the coil drivers |
| adc_clk | output | 1 | Converter clock |
| ser_clk | output | 1 | Serial bit clock |
| ser_frame | output | 1 | Serial frame, high while word bits are shifted |
| ser_data | output | 1 | Serial data, MSB first |
| dbg_clk | output | 1 | Copy of `adc_clk` |
| hf_power | output | 1 | High-frequency power output, held low |

## Verification
The assertions assume that `sel_125k`, `div_mode` and `div_value` change only while `rst` is high. The phase accumulator then always stays below the selected period. The stimulus follows this rule: each configuration is applied inside a reset pulse, and the configuration is held for the whole run that follows. `adc_sample` is also held steady around each capture edge, except in one directed test. That test changes it just after the capture on purpose, to show that the word already captured is kept.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  // Timing source picked by the divisor-mode pin.
  typedef enum logic {
    SRC_FIXED   = 1'b0,
    SRC_DIVISOR = 1'b1
  } lfc_src_e;

  // Larger of two integers, used to size the period word.
  function automatic int lfc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lfc_period_sel.sv
module lfc_period_sel
  import lfc_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_MIN   = 19,
  parameter int HALF_BASE = 11,
  parameter int SLOTS     = 16,
  parameter int PER_W     = 11
) (
  input  logic             div_mode,
  input  logic             sel_125k,
  input  logic [DIV_W-1:0] div_value,
  output logic [PER_W-1:0] period
);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(DIV_MIN);

  lfc_src_e         src;
  logic [DIV_W-1:0] div_eff;
  logic [PER_W-1:0] fixed_p;
  logic [PER_W-1:0] div_p;

  always_comb begin
    src     = lfc_src_e'(div_mode);
    div_eff = (div_value < FLOOR) ? FLOOR : div_value;
    fixed_p = PER_W'(SLOTS) * (PER_W'(HALF_BASE) + PER_W'(sel_125k));
    div_p   = (PER_W'(div_eff) + PER_W'(1)) << 1;
    period  = (src == SRC_DIVISOR) ? div_p : fixed_p;
  end
endmodule

// File: rtl/lfc_slot_timer.sv
module lfc_slot_timer #(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = 4,
  parameter int PER_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  period,
  output logic              enter,
  output logic [SLOT_W-1:0] next_slot
);
  localparam logic [PER_W-1:0]  STEP_INC  = PER_W'(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic              run_q;
  logic [PER_W-1:0]  acc_q;
  logic [PER_W-1:0]  acc_sum;
  logic [SLOT_W-1:0] slot_q;
  logic              step;

  always_comb begin
    acc_sum   = acc_q + STEP_INC;
    step      = run_q && (acc_sum >= period);
    enter     = !rst && (!run_q || step);
    if (!run_q || slot_q == LAST_SLOT) next_slot = '0;
    else                               next_slot = slot_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      acc_q  <= '0;
      slot_q <= '0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      acc_q  <= '0;
      slot_q <= '0;
    end else if (step) begin
      acc_q  <= acc_sum - period;
      slot_q <= next_slot;
    end else begin
      acc_q  <= acc_sum;
    end
  end

  AST_ACC_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (acc_q < period)); // R3
endmodule

// File: rtl/lfc_edge_shaper.sv
module lfc_edge_shaper #(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter,
  input  logic [SLOT_W-1:0] next_slot,
  output logic              coil_q,
  output logic              adc_q,
  output logic              sclk_q
);
  localparam logic [SLOT_W-1:0] MID = SLOT_W'(DATA_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      coil_q <= 1'b0;
      adc_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else if (enter) begin
      coil_q <= (next_slot < MID);
      adc_q  <= (next_slot >= MID);
      sclk_q <= next_slot[0];
    end
  end
endmodule

// File: rtl/lfc_word_serializer.sv
module lfc_word_serializer #(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter,
  input  logic [SLOT_W-1:0] next_slot,
  input  logic [DATA_W-1:0] sample,
  output logic              frame_q,
  output logic              data_q
);
  localparam logic [SLOT_W-1:0] MID = SLOT_W'(DATA_W);

  logic [DATA_W-1:0] held_q;
  logic              have_q;
  logic [DATA_W-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= '0;
      have_q  <= 1'b0;
      shift_q <= '0;
      frame_q <= 1'b0;
    end else if (enter) begin
      if (next_slot == MID) begin
        held_q <= sample;
        have_q <= 1'b1;
      end
      if (next_slot == '0) begin
        shift_q <= have_q ? held_q : '0;
        frame_q <= have_q;
      end else if (!next_slot[0]) begin
        shift_q <= shift_q << 1;
      end
    end
  end

  assign data_q = shift_q[DATA_W-1];
endmodule

// File: rtl/lfc_reader_front.sv
module lfc_reader_front #(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int DIV_MIN   = 19,
  parameter int HALF_BASE = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_125k,
  input  logic              div_mode,
  input  logic [DIV_W-1:0]  div_value,
  input  logic [DATA_W-1:0] adc_sample,
  output logic              coil_drive,
  output logic              adc_clk,
  output logic              ser_clk,
  output logic              ser_frame,
  output logic              ser_data,
  output logic              dbg_clk,
  output logic              hf_power
);
  localparam int SLOTS  = 2 * DATA_W;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int MAX_P  = lfc_pkg::lfc_max(2 * (2 ** DIV_W), SLOTS * (HALF_BASE + 1));
  localparam int PER_W  = $clog2(MAX_P + SLOTS) + 1;

  logic [PER_W-1:0]  period;
  logic              enter;
  logic [SLOT_W-1:0] next_slot;

  lfc_period_sel #(
    .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .HALF_BASE(HALF_BASE),
    .SLOTS(SLOTS), .PER_W(PER_W)
  ) u_period (
    .div_mode(div_mode), .sel_125k(sel_125k), .div_value(div_value),
    .period(period)
  );

  lfc_slot_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .period(period),
    .enter(enter), .next_slot(next_slot)
  );

  lfc_edge_shaper #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_shaper (
    .clk(clk), .rst(rst), .enter(enter), .next_slot(next_slot),
    .coil_q(coil_drive), .adc_q(adc_clk), .sclk_q(ser_clk)
  );

  lfc_word_serializer #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_ser (
    .clk(clk), .rst(rst), .enter(enter), .next_slot(next_slot),
    .sample(adc_sample), .frame_q(ser_frame), .data_q(ser_data)
  );

  assign dbg_clk  = adc_clk;
  assign hf_power = 1'b0;

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $changed(ser_data) |-> $fell(ser_clk)); // R5
  AST_FRAME_ON_CARRIER: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_frame) |-> $rose(coil_drive)); // R6
  AST_ADC_OPPOSES_COIL: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_clk) |-> $fell(coil_drive)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    (rst && $past(rst)) |-> !(coil_drive || adc_clk || ser_clk || ser_frame || ser_data)); // R10
endmodule

// File: tb/lfc_reader_front_test.sv
module lfc_reader_front_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_125k = 1'b1;
  logic       div_mode = 1'b0;
  logic [7:0] div_value = 8'd0;
  logic [7:0] adc_sample = 8'd0;
  logic coil_drive, adc_clk, ser_clk, ser_frame, ser_data, dbg_clk, hf_power;

  int checks = 0;
  int errors = 0;

  always #4 clk = !clk;

  lfc_reader_front uut (
    .clk(clk), .rst(rst), .sel_125k(sel_125k), .div_mode(div_mode),
    .div_value(div_value), .adc_sample(adc_sample),
    .coil_drive(coil_drive), .adc_clk(adc_clk), .ser_clk(ser_clk),
    .ser_frame(ser_frame), .ser_data(ser_data), .dbg_clk(dbg_clk),
    .hf_power(hf_power)
  );

  // {div_mode, sel_125k, div_value, sample, expected period in clocks}
  localparam int NV = 9;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'd5,   8'hA5, 10'd192},  // R1 fixed 125k, divisor ignored
    {1'b0, 1'b0, 8'd200, 8'h3C, 10'd176},  // R1 fixed ~136k
    {1'b1, 1'b0, 8'd95,  8'h80, 10'd192},  // R3 divisor 95
    {1'b1, 1'b1, 8'd10,  8'h01, 10'd40},   // R4 clamp
    {1'b1, 1'b0, 8'd19,  8'hFF, 10'd40},   // R4 floor value
    {1'b1, 1'b0, 8'd18,  8'h5A, 10'd40},   // R4 one below floor
    {1'b1, 1'b0, 8'd20,  8'hC3, 10'd42},   // R3 uneven slots
    {1'b1, 1'b0, 8'd255, 8'h00, 10'd512},  // R3 maximum
    {1'b1, 1'b1, 8'd0,   8'h96, 10'd40}    // R4 zero
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_cfg(input logic m, input logic s, input logic [7:0] d,
                           input logic [7:0] smp);
    @(negedge clk);
    rst = 1'b1; div_mode = m; sel_125k = s; div_value = d; adc_sample = smp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_vec(input logic [27:0] v);
    int p, fall_k, rise_k, frame_k, nbits, rises, k0_ok, side_bad;
    logic [7:0] word;
    logic prev_sc;
    p = int'(v[9:0]);
    start_cfg(v[27], v[26], v[25:18], v[17:10]);
    fall_k = -1; rise_k = -1; frame_k = -1; nbits = 0; rises = 0;
    k0_ok = 0; side_bad = 0; word = '0; prev_sc = 1'b0;
    for (int k = 0; k < 2 * p + 2; k++) begin
      @(negedge clk);
      if (k == 0) k0_ok = (coil_drive && !ser_frame) ? 1 : 0;
      if (!coil_drive && fall_k < 0) fall_k = k;
      if (fall_k >= 0 && coil_drive && rise_k < 0) rise_k = k;
      if (ser_frame && frame_k < 0) frame_k = k;
      if (ser_clk && !prev_sc && ser_frame && nbits < 8) begin
        word = {word[6:0], ser_data};
        nbits++;
      end
      if (ser_clk && !prev_sc && k >= p && k < 2 * p) rises++;
      if (adc_clk == coil_drive || dbg_clk != adc_clk || hf_power) side_bad = 1;
      prev_sc = ser_clk;
    end
    chk("R10 carrier starts high, frame low", k0_ok, 1);
    chk("R1/R3 half period", fall_k, p / 2);
    chk("R1/R3/R4 carrier period", rise_k, p);
    chk("R6 frame starts second period", frame_k, p);
    chk("R5/R7 word MSB first", int'(word), int'(v[17:10]));
    chk("R2 ser_clk rises per period", rises, 8);
    chk("R8/R9 adc, dbg, hf levels", side_bad, 0);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int adc_rise_k;
    int nb;
    logic [15:0] words;
    logic prev_sc;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10 reset outputs", int'({coil_drive, adc_clk, ser_clk, ser_frame, ser_data}), 0);
    chk("R9 hf_power low", int'(hf_power), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R10 reset mid-run forces outputs low
    start_cfg(1'b0, 1'b1, 8'd0, 8'h77);
    repeat (300) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid-run reset outputs", int'({coil_drive, adc_clk, ser_clk, ser_frame, ser_data}), 0);

    // R7 capture point and hold of the captured word
    start_cfg(1'b0, 1'b1, 8'd0, 8'hB4);
    adc_rise_k = -1; nb = 0; words = '0; prev_sc = 1'b0;
    for (int k = 0; k < 3 * 192 + 2; k++) begin
      @(negedge clk);
      if (adc_clk && adc_rise_k < 0) begin
        adc_rise_k = k;
        adc_sample = 8'h2D;  // change right after capture
      end
      if (ser_clk && !prev_sc && ser_frame && nb < 16) begin
        words = {words[14:0], ser_data};
        nb++;
      end
      prev_sc = ser_clk;
    end
    chk("R8 adc_clk rises mid period", adc_rise_k, 96);
    chk("R7 captured word kept", int'(words[15:8]), 8'hB4);
    chk("R7 next word uses new sample", int'(words[7:0]), 8'h2D);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule